// File: doc/BRIEF.md
# Timer Frame Access Control Register Block

This block is the control page of a memory-mapped system timer that serves several timer frames. For each frame it holds a small permission register. The register decides which of that frame's resources are exposed: the physical count, the virtual count, the frequency word, the virtual offset, the virtual timer and the physical timer. The permission bits of every frame drive out on a flat vector at all times, so each frame can gate its own register reads with them. A read-only identification word tells software which frames can present a virtual view.

Each frame has a fixed capability mask, set by a parameter. A permission bit can hold a one only where the mask allows it. Software learns what a frame implements by writing all ones to that frame's permission register and reading it back. Software treats a frame as usable in virtual mode only when the virtual-timer bit and the virtual-count bit both read back as one.

Top module: `tfac_ctrl_frame`

## Requirements
- R1: A synchronous active-low reset clears every permission register, the whole `perm_vec` output and `rd_data` to zero.
- R2: A write to byte offset 0x40 + 4n, where n is below NUM_FRAMES, stores `wr_data[5:0]` ANDed with frame n's capability mask. Bits 31:6 of the write data are ignored.
- R3: After any write, a permission bit that the frame does not implement reads back as zero. Writing all ones and reading back therefore returns exactly the capability mask.
- R4: The word at offset 0x08 is read-only. It has bit 4n+1 set for each frame n that can present a virtual view, and every other bit is zero. Writes to it change nothing.
- R5: Read data appears on `rd_data` in the cycle after `rd_en` is sampled high. In a cycle after `rd_en` was low, `rd_data` is zero.
- R6: A read at an offset that is not mapped returns zero, and a write there changes no register. Unmapped offsets include a misaligned offset, 0x00, and offsets past the last frame.
- R7: `perm_vec[6n+5:6n]` continuously carries frame n's permission register. Its fields are: bit 0 physical count read, bit 1 virtual count read, bit 2 frequency read, bit 3 virtual offset read, bit 4 virtual timer access, bit 5 physical timer access.
- R8: A frame whose mask lacks bit 1 or bit 4 never reads back with both bits 1 and 4 set, so software never judges it usable in virtual mode.
- R9: A write to one frame's register leaves every other frame's register unchanged.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| perm_vec | output | NUM_FRAMES*6 | Six permission bits per frame, frame 0 in the low bits |

## Verification
The assertions assume that `wr_en`, `rd_en` and `addr` are known and stable across each rising edge. They also assume that reset is held low for at least one edge before the first access. The stimulus meets this by changing every input only on falling edges and by holding reset low for three cycles at start-up. The stimulus walks every frame with all-ones, partial and upper-bit-only write patterns. It also writes to the read-only word, to a misaligned offset and to the offset just past the last frame. It then checks that these writes left no trace on `perm_vec` or on read-back.

// File: rtl/tfac_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the timer frame access control block.
// Assumes byte addressing with 32-bit aligned registers.
package tfac_pkg;
    localparam int PERM_W      = 6;        // permission bits per frame
    localparam int DATA_W      = 32;       // register width
    localparam int ID_OFFSET   = 'h008;    // read-only identification word
    localparam int FRAME_BASE  = 'h040;    // first per-frame permission register
    localparam int FRAME_PITCH = 4;        // bytes between permission registers

    // Permission bit positions (the timer frames decode these)
    localparam int B_PCNT_RD = 0;
    localparam int B_VCNT_RD = 1;
    localparam int B_FREQ_RD = 2;
    localparam int B_VOFS_RD = 3;
    localparam int B_VTMR_RW = 4;
    localparam int B_PTMR_RW = 5;

    // Position of the virtual-capable flag of a frame in the ID word
    localparam int ID_STRIDE   = 4;
    localparam int ID_VIRT_BIT = 1;
endpackage

// File: rtl/tfac_addr_decode.sv
`timescale 1ns/1ps
// Module: tfac_addr_decode
// Turns a byte offset into one-hot register selects: the ID word, or one
// permission register per frame. Assumes exact-match decoding, so any
// misaligned or out-of-range offset selects nothing.
module tfac_addr_decode
    import tfac_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int ADDR_W     = 12
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic                  id_hit,
    output logic [NUM_FRAMES-1:0] frame_hit
);
    // Identification word select
    assign id_hit = (addr == ADDR_W'(ID_OFFSET));

    // One comparator per frame register
    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_frame_dec
        localparam int FRAME_OFS = FRAME_BASE + FRAME_PITCH * n;
        assign frame_hit[n] = (addr == ADDR_W'(FRAME_OFS));
    end
endmodule

// File: rtl/tfac_perm_reg.sv
`timescale 1ns/1ps
// Module: tfac_perm_reg
// One frame's permission register. Only the bits set in CAP_MASK can hold
// a one; all other bits stay zero whatever is written. Assumes wr_stb is
// already qualified by the address decode.
module tfac_perm_reg
    import tfac_pkg::*;
#(
    parameter logic [PERM_W-1:0] CAP_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PERM_W-1:0] perm
);
    localparam logic [DATA_W-1:0] CAP_WIDE = DATA_W'(CAP_MASK);

    logic [PERM_W-1:0] perm_q;

    // Capture masked write data; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_q <= '0;
        end else if (wr_stb) begin
            perm_q <= PERM_W'(wr_data & CAP_WIDE);
        end
    end

    assign perm = perm_q;

    // R1: register is empty in the first cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (perm == '0));

    // R2: a write lands as the masked low bits of the data
    assert_write_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (perm == ($past(wr_data[PERM_W-1:0]) & CAP_MASK)));

    // R3: unimplemented bits never read as one
    assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm & ~CAP_MASK) == '0));

    // R9: no strobe means no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(perm));
endmodule

// File: rtl/tfac_rdata_mux.sv
`timescale 1ns/1ps
// Module: tfac_rdata_mux
// Selects the addressed register and registers it onto the read port.
// Assumes selects are one-hot or zero; with no select the word is zero.
module tfac_rdata_mux
    import tfac_pkg::*;
#(
    parameter int NUM_FRAMES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         id_hit,
    input  logic [NUM_FRAMES-1:0]        frame_hit,
    input  logic [DATA_W-1:0]            id_word,
    input  logic [NUM_FRAMES*PERM_W-1:0] perm_flat,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] sel_word;

    // Combinational choice of the addressed word
    always_comb begin
        sel_word = '0;
        if (id_hit) sel_word = id_word;
        for (int n = 0; n < NUM_FRAMES; n++) begin
            if (frame_hit[n]) sel_word = DATA_W'(perm_flat[n*PERM_W +: PERM_W]);
        end
    end

    // Register the read word; idle cycles return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? sel_word : '0;
        end
    end

    // R5: no read, no data
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R6: unmapped read returns zero
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !id_hit && (frame_hit == '0)) |=> (rd_data == '0));

    // R3: read-back never exposes bits above the permission field
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (frame_hit != '0)) |=> (rd_data[DATA_W-1:PERM_W] == '0));
endmodule

// File: rtl/tfac_ctrl_frame.sv
`timescale 1ns/1ps
// Module: tfac_ctrl_frame
// Control page of a memory-mapped timer: ID word of virtual-capable frames
// plus one capability-masked permission register per frame, all driven out
// on perm_vec. Assumes NUM_FRAMES <= 8 so every ID flag fits in 32 bits.
module tfac_ctrl_frame
    import tfac_pkg::*;
#(
    parameter int                              NUM_FRAMES = 8,
    parameter int                              ADDR_W     = 12,
    parameter logic [NUM_FRAMES*PERM_W-1:0]    CAP_MASKS  =
        {6'h1D, 6'h0A, 6'h3F, 6'h00, 6'h2F, 6'h13, 6'h25, 6'h3F},
    parameter logic [NUM_FRAMES-1:0]           VIRT_CAP   = 8'b0010_0101
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_FRAMES*PERM_W-1:0] perm_vec
);
    // Build the identification word from the virtual capability vector
    function automatic logic [DATA_W-1:0] build_id();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int n = 0; n < NUM_FRAMES; n++) begin
            if (VIRT_CAP[n]) w[ID_STRIDE*n + ID_VIRT_BIT] = 1'b1;
        end
        return w;
    endfunction

    localparam logic [DATA_W-1:0] ID_WORD = build_id();

    logic                  id_hit;
    logic [NUM_FRAMES-1:0] frame_hit;

    tfac_addr_decode #(
        .NUM_FRAMES (NUM_FRAMES),
        .ADDR_W     (ADDR_W)
    ) i_dec (
        .addr      (addr),
        .id_hit    (id_hit),
        .frame_hit (frame_hit)
    );

    // One permission register per frame
    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_perm
        tfac_perm_reg #(
            .CAP_MASK (CAP_MASKS[n*PERM_W +: PERM_W])
        ) i_perm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_en && frame_hit[n]),
            .wr_data (wr_data),
            .perm    (perm_vec[n*PERM_W +: PERM_W])
        );
    end

    tfac_rdata_mux #(
        .NUM_FRAMES (NUM_FRAMES)
    ) i_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .id_hit    (id_hit),
        .frame_hit (frame_hit),
        .id_word   (ID_WORD),
        .perm_flat (perm_vec),
        .rd_data   (rd_data)
    );

    // R6: at most one register selected by any offset
    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({id_hit, frame_hit}));

    // R4: the ID word reads back as the fixed capability pattern
    assert_id_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_hit) |=> (rd_data == ID_WORD));

    // R6: a write to an unmapped offset leaves every frame untouched
    assert_unmapped_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (frame_hit == '0)) |=> $stable(perm_vec));
endmodule

// File: tb/test_tfac_ctrl_frame.sv
`timescale 1ns/1ps
// Bench for tfac_ctrl_frame: a vector table walked by one loop, then
// directed checks for reset, idle read, same-cycle read/write and output vector.
module test_tfac_ctrl_frame;
    localparam int NF = 8;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NF*6-1:0] perm_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    tfac_ctrl_frame i_tfac_ctrl_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .perm_vec (perm_vec)
    );

    typedef struct packed {
        logic        is_rd;
        logic [3:0]  req;
        logic [11:0] ofs;
        logic [31:0] wdat;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        {1'b0, 4'd0, 12'h040, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd3, 12'h040, 32'h0, 32'h0000_003F},    // R3 frame0 full
        {1'b0, 4'd0, 12'h044, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd3, 12'h044, 32'h0, 32'h0000_0025},    // R3 frame1 mask
        {1'b0, 4'd0, 12'h048, 32'h0000_0015, 32'h0},
        {1'b1, 4'd2, 12'h048, 32'h0, 32'h0000_0011},    // R2 partial
        {1'b0, 4'd0, 12'h04C, 32'hFFFF_FFC0, 32'h0},
        {1'b1, 4'd2, 12'h04C, 32'h0, 32'h0000_0000},    // R2 upper bits ignored
        {1'b0, 4'd0, 12'h04C, 32'h0000_003F, 32'h0},
        {1'b1, 4'd3, 12'h04C, 32'h0, 32'h0000_002F},    // R3
        {1'b0, 4'd0, 12'h050, 32'h0000_00FF, 32'h0},
        {1'b1, 4'd3, 12'h050, 32'h0, 32'h0000_0000},    // R3 empty frame
        {1'b0, 4'd0, 12'h05C, 32'h0000_00FF, 32'h0},
        {1'b1, 4'd8, 12'h05C, 32'h0, 32'h0000_001D},    // R8 no virtual count
        {1'b0, 4'd0, 12'h058, 32'h0000_00FF, 32'h0},
        {1'b1, 4'd3, 12'h058, 32'h0, 32'h0000_000A},    // R3
        {1'b0, 4'd0, 12'h054, 32'h0000_002A, 32'h0},
        {1'b1, 4'd2, 12'h054, 32'h0, 32'h0000_002A},    // R2
        {1'b1, 4'd4, 12'h008, 32'h0, 32'h0020_0202},    // R4 ID word
        {1'b0, 4'd0, 12'h008, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd4, 12'h008, 32'h0, 32'h0020_0202},    // R4 write ignored
        {1'b0, 4'd0, 12'h060, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd6, 12'h060, 32'h0, 32'h0000_0000},    // R6 past last frame
        {1'b1, 4'd9, 12'h040, 32'h0, 32'h0000_003F},    // R9 frame0 intact
        {1'b0, 4'd0, 12'h041, 32'h0000_0000, 32'h0},
        {1'b1, 4'd6, 12'h040, 32'h0, 32'h0000_003F},    // R6 misaligned write
        {1'b1, 4'd6, 12'h000, 32'h0, 32'h0000_0000},    // R6 offset zero
        {1'b1, 4'd9, 12'h044, 32'h0, 32'h0000_0025}     // R9 frame1 intact
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read lands on rd_data after one edge; sampled on the next falling edge
    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 64'(perm_vec), 64'h0);
        check("R1", 64'(rd_data), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        do_read(12'h040, rv);
        check("R1", 64'(rv), 64'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd) begin
                do_read(VEC[i].ofs, rv);
                check(req_name(VEC[i].req), 64'(rv), 64'(VEC[i].exp));
            end else begin
                do_write(VEC[i].ofs, VEC[i].wdat);
            end
        end

        // R8: frame 1 after all ones never shows both virtual bits
        do_read(12'h044, rv);
        check("R8", 64'(rv[1] & rv[4]), 64'h0);

        // R7: the whole output vector, frame 0 in the low bits
        check("R7", 64'(perm_vec),
              64'({6'h1D, 6'h0A, 6'h2A, 6'h00, 6'h2F, 6'h11, 6'h25, 6'h3F}));

        // R5: idle cycle after a read returns zero
        do_read(12'h040, rv);
        @(negedge clk);
        check("R5", 64'(rd_data), 64'h0);

        // R10: same-cycle read and write of frame 0 returns the old value
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h040; wr_data = 32'h0;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10", 64'(rd_data), 64'h3F);
        check("R10", 64'(perm_vec[5:0]), 64'h0);

        // R1: reset in mid-run clears every frame
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 64'(perm_vec), 64'h0);
        rst_n = 1'b1;
        do_read(12'h04C, rv);
        check("R1", 64'(rv), 64'h0);

        done = 1'b1;
        summary();
    end
endmodule